// File: doc/BRIEF.md
# Programmable External Chip-Select Unit

This block holds a bank of chip-select channels for a microcontroller's external bus. Software programs each channel with a base-address register and an option register. On every bus cycle, each channel compares the cycle's address, address space, direction, byte lanes and, on interrupt-acknowledge cycles, the interrupt level against its programmed values. A channel whose values all match pulls its active-low select pin low. When the cycle targets an on-chip module, the `int_hit` input is raised, and no select is driven even if a channel matches.

Channel 0 is the boot channel. It is live straight out of reset and covers the lowest 256 KiB. The other channels stay off until software writes a non-zero lane code into their option register. The channels share one bus-cycle acknowledge generator. It counts the wait states programmed in the lowest-numbered matching channel. That channel can instead request fast termination, leave termination to an external device, or return an autovector acknowledge on interrupt-acknowledge cycles. A pin-function register decides, pin by pin, whether the pin carries the chip select or a software-driven level from a pin data register. The same register also records each pin's port width, which is reported alongside the acknowledge.

Top module: `cs_unit`

## Requirements
- R1: Reset state. Every pin is high, the acknowledge outputs are low and `cfg_err` is low. Channel 0 is programmed to base 0, block code 7, both lanes, read and write, user or supervisor space, wait code 13. All other channels hold zero.
- R2: Selects are active low and registered. An access that matches a channel drives that pin low on the clock edge after the cycle inputs are presented. The pin is re-evaluated on every edge.
- R3: Base register layout: bits 15:3 hold address bits 23:11 and bits 2:0 hold block code c. The channel compares address bits 23 down to 11+c, so its block is 2 KiB shifted left by c.
- R4: Option register bits 3:2 give direction, with bit 2 allowing reads (`cyc_rw`=1) and bit 3 allowing writes. Bits 10:9 give the space: 0 = interrupt acknowledge (`cyc_space`=0, and `cyc_ipl` must equal option bits 13:11), 1 = user (`cyc_space`=1), 2 = supervisor (`cyc_space`=2), 3 = user or supervisor.
- R5: Option bits 1:0 give the lanes: bit 0 is the lower byte, bit 1 the upper byte. The channel matches only when the accessed lanes `cyc_lane` share at least one lane with them.
- R6: While `int_hit` is high, no pin configured as a chip select goes low and no acknowledge is produced for that cycle.
- R7: With option bit 4 set, the select waits for the data strobe `cyc_ds` as well as `cyc_as`. With bit 4 clear, `cyc_as` alone is enough.
- R8: A channel whose lane code is 00 never selects.
- R9: Option bits 8:5 hold wait code w. If the cycle's inputs are presented before edge E, then a code w from 0 to 13 raises the acknowledge after edge E+w+1, and code 14 raises it after edge E. Code 15 produces no acknowledge. The acknowledge stays high until `cyc_as` falls.
- R10: When several channels match, the lowest-numbered one sets the acknowledge timing and kind.
- R11: If the winning channel has option bit 14 set and the cycle is an interrupt acknowledge, `avec_o` is raised in place of `ack_o`.
- R12: Register 2N holds pin functions in bits N-1:0 (1 = chip select, 0 = discrete) and port widths in bits 2N-1:N (1 = 16-bit). A discrete pin follows bit k of register 2N+1 one edge after the write, and it ignores bus cycles. A channel whose pin is discrete does not acknowledge.
- R13: Writing register 2k+1 (option) before register 2k (base) of the same channel sets the sticky `cfg_err`. Channel 0 counts its base as already written.
- R14: `ack_wide` accompanies `ack_o` and reports the width bit of the winning channel. It is low with `avec_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | RSW | Register index: 2k base, 2k+1 option, 2N function, 2N+1 pin data |
| wr_data | input | 16 | Write data |
| cyc_as | input | 1 | Address strobe, high for the whole bus cycle |
| cyc_addr | input | 24 | Cycle address |
| cyc_space | input | 2 | 0 interrupt acknowledge, 1 user, 2 supervisor |
| cyc_rw | input | 1 | 1 read, 0 write |
| cyc_lane | input | 2 | Accessed lanes, bit 0 lower, bit 1 upper |
| cyc_ipl | input | 3 | Interrupt level on acknowledge cycles |
| cyc_ds | input | 1 | Data strobe |
| int_hit | input | 1 | Access decodes to an on-chip target |
| pin_n | output | N | Pin levels, active-low selects |
| ack_o | output | 1 | Shared transfer acknowledge |
| avec_o | output | 1 | Autovector acknowledge |
| ack_wide | output | 1 | Port width of the winning channel |
| cfg_err | output | 1 | Sticky programming-order error |

## Verification
On every cycle, the assertions check the following. A low select is always preceded by an active address strobe. An internal hit always leaves every chip-select pin high. Discrete pins track the pin data register. The two acknowledges are never raised together, and neither is raised outside a bus cycle. The error flag never clears. Only the bench scenarios can show the exact wait-state counts, the masking by block size, lane and space decoding, lowest-channel priority and the width reported with each acknowledge, because those results depend on values that were programmed earlier.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W   = 24;
  localparam int BASE_LSB = 11;
  localparam int UPPER_W  = ADDR_W - BASE_LSB;

  localparam logic [3:0] WAIT_FAST = 4'd14;
  localparam logic [3:0] WAIT_EXT  = 4'd15;

  localparam logic [1:0] SP_IACK = 2'd0;
  localparam logic [1:0] SP_USER = 2'd1;
  localparam logic [1:0] SP_SUPV = 2'd2;
  localparam logic [1:0] SP_ANY  = 2'd3;

  typedef struct packed {
    logic [UPPER_W-1:0] upper;
    logic [2:0]         blk;
  } base_t;

  typedef struct packed {
    logic       avec;
    logic [2:0] ipl;
    logic [1:0] space;
    logic [3:0] wcode;
    logic       ds_gate;
    logic [1:0] rw;
    logic [1:0] lanes;
  } opt_t;

  localparam base_t BOOT_BASE = '{upper: '0, blk: 3'd7};
  localparam opt_t  BOOT_OPT  = '{avec: 1'b0, ipl: 3'd0, space: SP_ANY,
                                  wcode: 4'd13, ds_gate: 1'b0,
                                  rw: 2'b11, lanes: 2'b11};

  typedef enum logic [1:0] {AK_IDLE, AK_WAIT, AK_HOLD} ak_state_t;

  // Address compare above the block-size boundary.
  function automatic logic addr_hit(base_t b, logic [ADDR_W-1:0] a);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < UPPER_W; i++) begin
      if (i >= int'(b.blk) && a[BASE_LSB+i] != b.upper[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic space_hit(opt_t o, logic [1:0] sp, logic [2:0] lvl);
    case (o.space)
      SP_IACK: return (sp == SP_IACK) && (lvl == o.ipl);
      SP_USER: return sp == SP_USER;
      SP_SUPV: return sp == SP_SUPV;
      default: return (sp == SP_USER) || (sp == SP_SUPV);
    endcase
  endfunction

  function automatic logic rw_hit(opt_t o, logic rd);
    return rd ? o.rw[0] : o.rw[1];
  endfunction

  function automatic logic lane_hit(opt_t o, logic [1:0] ln);
    return (o.lanes & ln) != 2'b00;
  endfunction
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_pkg::*;
#(
  parameter int NCH = 4,
  localparam int RSW = $clog2(2*NCH+2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RSW-1:0]       wr_sel,
  input  logic [15:0]          wr_data,
  output base_t [NCH-1:0]      base_o,
  output opt_t  [NCH-1:0]      opt_o,
  output logic  [NCH-1:0]      fn_cs_o,
  output logic  [NCH-1:0]      wide_o,
  output logic  [NCH-1:0]      pdr_o,
  output logic                 cfg_err_o
);
  localparam logic [RSW-1:0] SEL_PAR = RSW'(2*NCH);
  localparam logic [RSW-1:0] SEL_PDR = RSW'(2*NCH+1);

  logic [NCH-1:0] order_err;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam base_t RST_B = (k == 0) ? BOOT_BASE : '0;
    localparam opt_t  RST_O = (k == 0) ? BOOT_OPT  : '0;
    localparam logic [RSW-1:0] SEL_B = RSW'(2*k);
    localparam logic [RSW-1:0] SEL_O = RSW'(2*k+1);
    base_t b_q;
    opt_t  o_q;
    logic  seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q    <= RST_B;
        o_q    <= RST_O;
        seen_q <= (k == 0);
      end else if (wr_en) begin
        if (wr_sel == SEL_B) begin
          b_q    <= base_t'(wr_data);
          seen_q <= 1'b1;
        end
        if (wr_sel == SEL_O) o_q <= opt_t'(wr_data[14:0]);
      end
    end
    assign order_err[k] = wr_en && (wr_sel == SEL_O) && !seen_q;
    assign base_o[k] = b_q;
    assign opt_o[k]  = o_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_cs_o   <= '1;
      wide_o    <= '1;
      pdr_o     <= '1;
      cfg_err_o <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_PAR) begin
        fn_cs_o <= wr_data[NCH-1:0];
        wide_o  <= wr_data[2*NCH-1:NCH];
      end
      if (wr_en && wr_sel == SEL_PDR) pdr_o <= wr_data[NCH-1:0];
      if (|order_err) cfg_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_pkg::*;
#(
  parameter int NCH = 4
) (
  input  base_t [NCH-1:0]    base_i,
  input  opt_t  [NCH-1:0]    opt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         space_i,
  input  logic               rd_i,
  input  logic [1:0]         lane_i,
  input  logic [2:0]         ipl_i,
  input  logic               ds_i,
  output logic [NCH-1:0]     match_o,
  output logic [NCH-1:0]     strobe_ok_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    logic en;
    assign en = opt_i[k].lanes != 2'b00;
    assign match_o[k] = en
                        && addr_hit(base_i[k], addr_i)
                        && space_hit(opt_i[k], space_i, ipl_i)
                        && rw_hit(opt_i[k], rd_i)
                        && lane_hit(opt_i[k], lane_i);
    assign strobe_ok_o[k] = !opt_i[k].ds_gate || ds_i;
  end
endmodule

// File: rtl/cs_ack_gen.sv
module cs_ack_gen
  import cs_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic [NCH-1:0]    hit_i,
  input  opt_t [NCH-1:0]    opt_i,
  input  logic [NCH-1:0]    wide_i,
  input  logic [1:0]        space_i,
  output logic              ack_o,
  output logic              avec_o,
  output logic              wide_o,
  output logic              start_o,
  output logic              fire_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  ak_state_t   state_q;
  logic [3:0]  cnt_q;
  logic        win_avec_q, win_wide_q;
  logic [IW-1:0] win;
  logic        any_hit, cur_avec, cur_wide;
  logic [3:0]  cur_code;

  // Lowest-numbered hit wins.
  always_comb begin
    win = '0;
    for (int k = NCH-1; k >= 0; k--) begin
      if (hit_i[k]) win = IW'(k);
    end
  end

  assign any_hit  = |hit_i;
  assign cur_code = opt_i[win].wcode;
  assign cur_avec = opt_i[win].avec && (space_i == SP_IACK);
  assign cur_wide = wide_i[win] && !cur_avec;
  assign start_o  = as_i && (state_q == AK_IDLE);
  assign fire_o   = as_i && ((start_o && any_hit && cur_code == WAIT_FAST)
                    || (state_q == AK_WAIT && cnt_q == 4'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= AK_IDLE;
      cnt_q      <= '0;
      win_avec_q <= 1'b0;
      win_wide_q <= 1'b0;
      ack_o      <= 1'b0;
      avec_o     <= 1'b0;
      wide_o     <= 1'b0;
    end else if (!as_i) begin
      state_q <= AK_IDLE;
      ack_o   <= 1'b0;
      avec_o  <= 1'b0;
      wide_o  <= 1'b0;
    end else begin
      case (state_q)
        AK_IDLE: begin
          win_avec_q <= cur_avec;
          win_wide_q <= cur_wide;
          if (!any_hit || cur_code == WAIT_EXT) begin
            state_q <= AK_HOLD;
          end else if (cur_code == WAIT_FAST) begin
            ack_o   <= !cur_avec;
            avec_o  <= cur_avec;
            wide_o  <= cur_wide;
            state_q <= AK_HOLD;
          end else begin
            cnt_q   <= cur_code;
            state_q <= AK_WAIT;
          end
        end
        AK_WAIT: begin
          if (cnt_q == 4'd0) begin
            ack_o   <= !win_avec_q;
            avec_o  <= win_avec_q;
            wide_o  <= win_wide_q;
            state_q <= AK_HOLD;
          end else begin
            cnt_q <= cnt_q - 4'd1;
          end
        end
        default: state_q <= AK_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/cs_unit.sv
module cs_unit
  import cs_pkg::*;
#(
  parameter int NCH = 4,
  localparam int RSW = $clog2(2*NCH+2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RSW-1:0]    wr_sel,
  input  logic [15:0]       wr_data,
  input  logic              cyc_as,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [1:0]        cyc_space,
  input  logic              cyc_rw,
  input  logic [1:0]        cyc_lane,
  input  logic [2:0]        cyc_ipl,
  input  logic              cyc_ds,
  input  logic              int_hit,
  output logic [NCH-1:0]    pin_n,
  output logic              ack_o,
  output logic              avec_o,
  output logic              ack_wide,
  output logic              cfg_err
);
  base_t [NCH-1:0] base_w;
  opt_t  [NCH-1:0] opt_w;
  logic  [NCH-1:0] fn_cs, wide_bits, pdr_bits;
  logic  [NCH-1:0] match_w, strobe_ok;
  logic  [NCH-1:0] sel_event, ack_hit;
  logic  [NCH-1:0] pin_d;
  logic            ack_start, ack_fire;

  cs_regfile #(.NCH(NCH)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .base_o(base_w), .opt_o(opt_w),
    .fn_cs_o(fn_cs), .wide_o(wide_bits), .pdr_o(pdr_bits),
    .cfg_err_o(cfg_err)
  );

  cs_match #(.NCH(NCH)) match_i (
    .base_i(base_w), .opt_i(opt_w), .addr_i(cyc_addr),
    .space_i(cyc_space), .rd_i(cyc_rw), .lane_i(cyc_lane),
    .ipl_i(cyc_ipl), .ds_i(cyc_ds),
    .match_o(match_w), .strobe_ok_o(strobe_ok)
  );

  // Internal hits and discrete pins take a channel out of the decode.
  assign ack_hit   = match_w & fn_cs & {NCH{!int_hit}};
  assign sel_event = ack_hit & strobe_ok & {NCH{cyc_as}};

  cs_ack_gen #(.NCH(NCH)) ack_i (
    .clk(clk), .rst_n(rst_n), .as_i(cyc_as), .hit_i(ack_hit),
    .opt_i(opt_w), .wide_i(wide_bits), .space_i(cyc_space),
    .ack_o(ack_o), .avec_o(avec_o), .wide_o(ack_wide),
    .start_o(ack_start), .fire_o(ack_fire)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_pin
    assign pin_d[k] = fn_cs[k] ? !sel_event[k] : pdr_bits[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_n <= '1;
    else        pin_n <= pin_d;
  end
endmodule

// File: rtl/cs_unit_chk.sv
module cs_unit_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cyc_as,
  input logic           int_hit,
  input logic [NCH-1:0] pin_n,
  input logic           ack_o,
  input logic           avec_o,
  input logic           cfg_err,
  input logic [NCH-1:0] fn_cs,
  input logic [NCH-1:0] pdr_bits
);
  assert_sel_needs_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pin_n & $past(fn_cs)) != '0) |-> $past(cyc_as));

  assert_int_hit_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |=> ((pin_n | ~$past(fn_cs)) == '1));

  assert_ack_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && avec_o));

  assert_ack_in_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o || avec_o) |-> $past(cyc_as));

  assert_discrete_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_n ^ $past(pdr_bits)) & ~$past(fn_cs)) == '0);

  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> cfg_err);
endmodule

bind cs_unit cs_unit_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_as(cyc_as), .int_hit(int_hit),
  .pin_n(pin_n), .ack_o(ack_o), .avec_o(avec_o), .cfg_err(cfg_err),
  .fn_cs(fn_cs), .pdr_bits(pdr_bits)
);

// File: tb/cs_unit_tb_top.sv
`timescale 1ns/1ps
module cs_unit_tb_top;
  localparam int NCH = 4;
  localparam int RSW = $clog2(2*NCH+2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [RSW-1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic cyc_as = 1'b0, cyc_rw = 1'b1, cyc_ds = 1'b0, int_hit = 1'b0;
  logic [23:0] cyc_addr = '0;
  logic [1:0] cyc_space = 2'd1, cyc_lane = 2'd3;
  logic [2:0] cyc_ipl = '0;
  logic [NCH-1:0] pin_n;
  logic ack_o, avec_o, ack_wide, cfg_err;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int   due_q[$];
  int   kind_q[$];
  logic [7:0] exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cs_unit #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cyc_as(cyc_as), .cyc_addr(cyc_addr),
    .cyc_space(cyc_space), .cyc_rw(cyc_rw), .cyc_lane(cyc_lane),
    .cyc_ipl(cyc_ipl), .cyc_ds(cyc_ds), .int_hit(int_hit),
    .pin_n(pin_n), .ack_o(ack_o), .avec_o(avec_o),
    .ack_wide(ack_wide), .cfg_err(cfg_err)
  );

  // Monitor: pops scoreboard items when they fall due.
  always @(negedge clk) begin
    for (int i = due_q.size() - 1; i >= 0; i--) begin
      if (due_q[i] == cyc) begin
        logic [7:0] act;
        case (kind_q[i])
          0:       act = {4'b0, pin_n};
          1:       act = {5'b0, avec_o, ack_o, ack_wide};
          default: act = {7'b0, cfg_err};
        endcase
        tests++;
        if (act !== exp_q[i]) begin
          fails++;
          $display("FAIL %s kind %0d actual %0h expected %0h at cycle %0d",
                   req_q[i], kind_q[i], act, exp_q[i], cyc);
        end
        due_q.delete(i); kind_q.delete(i); exp_q.delete(i); req_q.delete(i);
      end
    end
  end

  task automatic expect_at(input int dly, input int kind, input logic [7:0] v,
                           input string r);
    due_q.push_back(cyc + dly);
    kind_q.push_back(kind);
    exp_q.push_back(v);
    req_q.push_back(r);
  endtask

  task automatic wr(input int sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = RSW'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One bus cycle; ack_dly 0 means no acknowledge is expected.
  task automatic bus(input logic [23:0] a, input logic [1:0] sp, input logic rd,
                     input logic [1:0] ln, input logic [2:0] lvl, input logic ds,
                     input logic hit, input logic [3:0] exp_pins, input string rp,
                     input int ack_dly, input logic [2:0] exp_ack, input string ra);
    int hold;
    hold = (ack_dly > 0) ? ack_dly + 1 : 4;
    cyc_addr = a; cyc_space = sp; cyc_rw = rd; cyc_lane = ln; cyc_ipl = lvl;
    cyc_ds = ds; int_hit = hit; cyc_as = 1'b1;
    expect_at(1, 0, {4'b0, exp_pins}, rp);
    if (ack_dly > 1) expect_at(ack_dly - 1, 1, 8'h00, ra);
    if (ack_dly > 0) expect_at(ack_dly, 1, {5'b0, exp_ack}, ra);
    else             expect_at(hold, 1, 8'h00, ra);
    repeat (hold) @(negedge clk);
    cyc_as = 1'b0; cyc_ds = 1'b0; int_hit = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..all: run did not complete, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_at(1, 0, 8'h0F, "R1 reset pins");
    expect_at(1, 1, 8'h00, "R1 reset ack");
    expect_at(1, 2, 8'h00, "R1 reset cfg_err");
    repeat (2) @(negedge clk);
    // R13 boot option rewrite is legal, ch1 option before base is not
    wr(1, 16'h07AF);
    expect_at(1, 2, 8'h00, "R13 boot order ok");
    repeat (2) @(negedge clk);
    wr(3, 16'h0000);
    expect_at(1, 2, 8'h01, "R13 order error");
    repeat (2) @(negedge clk);
    // R1/R9 boot channel, wait 13
    bus(24'h001000, 2'd1, 1'b1, 2'd3, 3'd0, 1'b0, 1'b0, 4'b1110, "R1 boot select",
        15, 3'b011, "R9 boot wait 13");
    bus(24'h040000, 2'd1, 1'b1, 2'd3, 3'd0, 1'b0, 1'b0, 4'b1111, "R3 above boot block",
        0, 3'b000, "R3 no ack");
    // R8 channel 1 disabled until lanes set
    wr(2, 16'h1000);
    bus(24'h100000, 2'd1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 4'b1111, "R8 disabled",
        0, 3'b000, "R8 no ack");
    wr(3, 16'h060D);
    bus(24'h100000, 2'd1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 4'b1101, "R2 ch1 select",
        2, 3'b011, "R9 wait 0");
    bus(24'h100000, 2'd1, 1'b1, 2'd2, 3'd0, 1'b0, 1'b0, 4'b1111, "R5 wrong lane",
        0, 3'b000, "R5 no ack");
    bus(24'h100000, 2'd1, 1'b1, 2'd3, 3'd0, 1'b0, 1'b0, 4'b1101, "R5 word access",
        2, 3'b011, "R5 ack");
    bus(24'h100800, 2'd1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 4'b1111, "R3 past 2K block",
        0, 3'b000, "R3 no ack");
    bus(24'h1007FE, 2'd1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 4'b1101, "R3 top of block",
        2, 3'b011, "R3 ack");
    // R4 direction
    wr(3, 16'h0605);
    bus(24'h100000, 2'd1, 1'b0, 2'd1, 3'd0, 1'b0, 1'b0, 4'b1111, "R4 write refused",
        0, 3'b000, "R4 no ack");
    bus(24'h100000, 2'd1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 4'b1101, "R4 read allowed",
        2, 3'b011, "R4 ack");
    // R6 internal hit
    bus(24'h100000, 2'd1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b1, 4'b1111, "R6 internal hit",
        0, 3'b000, "R6 no ack");
    // R7 data strobe gating, fast ack, supervisor space
    wr(4, 16'h2001);
    wr(5, 16'h05DF);
    bus(24'h200FFF, 2'd2, 1'b1, 2'd3, 3'd0, 1'b0, 1'b0, 4'b1111, "R7 wait for ds",
        1, 3'b011, "R9 fast");
    bus(24'h200FFF, 2'd2, 1'b1, 2'd3, 3'd0, 1'b1, 1'b0, 4'b1011, "R7 with ds",
        1, 3'b011, "R9 fast");
    bus(24'h200000, 2'd1, 1'b1, 2'd3, 3'd0, 1'b1, 1'b0, 4'b1111, "R4 user refused",
        0, 3'b000, "R4 no ack");
    // R10 overlapping channels
    wr(6, 16'h1000);
    wr(7, 16'h064F);
    bus(24'h100000, 2'd1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 4'b0101, "R10 both select",
        2, 3'b011, "R10 ch1 timing");
    bus(24'h100000, 2'd1, 1'b1, 2'd2, 3'd0, 1'b0, 1'b0, 4'b0111, "R10 ch3 only",
        4, 3'b011, "R10 ch3 wait 2");
    // R14 port width
    wr(8, 16'h00DF);
    bus(24'h100000, 2'd1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 4'b0101, "R14 select",
        2, 3'b010, "R14 narrow port");
    // R9 external termination
    wr(7, 16'h07EF);
    bus(24'h100000, 2'd1, 1'b1, 2'd2, 3'd0, 1'b0, 1'b0, 4'b0111, "R2 ch3 select",
        0, 3'b000, "R9 external no ack");
    // R11 interrupt acknowledge with autovector
    wr(5, 16'h6807);
    bus(24'h200000, 2'd0, 1'b1, 2'd3, 3'd5, 1'b0, 1'b0, 4'b1011, "R11 iack select",
        2, 3'b100, "R11 autovector");
    bus(24'h200000, 2'd0, 1'b1, 2'd3, 3'd3, 1'b0, 1'b0, 4'b1111, "R4 wrong level",
        0, 3'b000, "R4 no ack");
    // R12 discrete output
    wr(8, 16'h00D7);
    wr(9, 16'h0000);
    expect_at(1, 0, 8'h07, "R12 discrete low");
    repeat (2) @(negedge clk);
    bus(24'h100000, 2'd1, 1'b1, 2'd2, 3'd0, 1'b0, 1'b0, 4'b0111, "R12 cycle ignored",
        0, 3'b000, "R12 no ack");
    wr(9, 16'h0008);
    expect_at(1, 0, 8'h0F, "R12 discrete high");
    repeat (4) @(negedge clk);
    if (due_q.size() != 0) begin
      fails++;
      $display("FAIL R1..all: %0d pending checks, expected 0", due_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule